// File: doc/BRIEF.md
# Guarded-Write Predicate Register File

This block holds the one-bit predicate registers of a wide-issue machine. Every issue slot of an instruction word names one predicate register. In the same cycle, before the end of operand fetch, the block returns a pass flag for that slot. A slot that reads 1 goes on to execute. A slot that reads 0 is squashed into a no-op by the pipeline around the block.

The predicates are written through a few write ports. Each port carries one of three operations, or none:
- **Guarded set** stores a boolean in the destination, but only when the port's own guard predicate reads 1.
- **Guarded inverted set** does the same with the complement of the boolean.
- **Loop compare** is unguarded. It stores whether an iteration counter is below a loop bound, and that flag then steers the next iteration.

Register 0 always reads 1, so an operation with no predicate always passes. All writes take effect at the clock edge.

Top module: `predRegFile`

## Requirements
- R1: After reset, every register from 1 to 127 reads 0 and register 0 reads 1.
- R2: Register 0 always reads 1. Any write whose destination is 0 is dropped.
- R3: Each of the 7 slots returns, combinationally and independently of the others, the value of the register named by its 7-bit index at `slotIdx[s*7 +: 7]`. A value of 1 means pass and 0 means squash.
- R4: Op code 2'b01 (guarded set) on a port whose guard register reads 1 stores `wrVal[p]` in the destination register.
- R5: Op code 2'b10 (guarded inverted set) on a port whose guard register reads 1 stores `~wrVal[p]` in the destination register.
- R6: A guarded set or guarded inverted set whose guard register reads 0 leaves the destination unchanged.
- R7: Op code 2'b11 (loop compare) ignores the guard. It stores 1 when the 32-bit counter is below the 32-bit bound as unsigned numbers, and 0 otherwise.
- R8: A write becomes visible from the cycle after its clock edge. Reads and guard lookups in the same cycle see the old value.
- R9: When two ports write the same register in one cycle, the higher-numbered port's value is kept.
- R10: Op code 2'b00 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotIdx | input | NUM_SLOTS*7 | Predicate index per issue slot, slot s at bits s*7 +: 7 |
| slotPass | output | NUM_SLOTS | Per-slot pass (1) or squash (0) |
| wrOp | input | NUM_WR*2 | Op code per write port, port p at bits p*2 +: 2 |
| wrGuard | input | NUM_WR*7 | Guard register index per write port |
| wrDest | input | NUM_WR*7 | Destination register index per write port |
| wrVal | input | NUM_WR | Boolean value per write port |
| loopCount | input | NUM_WR*CNT_W | Iteration counter per write port |
| loopBound | input | NUM_WR*CNT_W | Loop bound per write port |

## Verification
The guarded writes are tried with the guard at 1 and at 0, in both the plain and the inverted form. This separates a missing guard check from a swapped polarity. The loop compare is tried with the counter below, equal to and above the bound, and with all-ones operands. These cases catch an off-by-one and a signed compare. Two ports aimed at the same register, in both value orders, expose a wrong port priority. Writes aimed at register 0 expose a register 0 that can be overwritten. A long random run over a small index range then checks all seven slots every cycle against a reference copy of the registers.

// File: rtl/predPkg.sv
package predPkg;
  localparam int PRED_COUNT = 128;
  localparam int IDX_W      = $clog2(PRED_COUNT);

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_SET    = 2'b01,
    OP_SETINV = 2'b10,
    OP_LOOP   = 2'b11
  } predOp_e;

  // Strobes handed from control to datapath for one write port.
  typedef struct packed {
    logic             we;
    logic [IDX_W-1:0] dest;
    logic             data;
  } wrStrobe_t;
endpackage

// File: rtl/predCtrl.sv
module predCtrl
  import predPkg::*;
#(
  parameter int NUM_WR = 2,
  parameter int CNT_W  = 32
) (
  input  logic [NUM_WR*2-1:0]     wrOp,
  input  logic [NUM_WR*IDX_W-1:0] wrDest,
  input  logic [NUM_WR-1:0]       wrVal,
  input  logic [NUM_WR*CNT_W-1:0] loopCount,
  input  logic [NUM_WR*CNT_W-1:0] loopBound,
  input  logic [NUM_WR-1:0]       guardPass,
  output wrStrobe_t               strobes [NUM_WR]
);
  for (genvar p = 0; p < NUM_WR; p++) begin : g_port
    predOp_e          opCode;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] bnd;

    assign opCode = predOp_e'(wrOp[p*2 +: 2]);
    assign cnt    = loopCount[p*CNT_W +: CNT_W];
    assign bnd    = loopBound[p*CNT_W +: CNT_W];

    always_comb begin
      strobes[p].dest = wrDest[p*IDX_W +: IDX_W];
      strobes[p].we   = 1'b0;
      strobes[p].data = 1'b0;
      unique case (opCode)
        OP_SET: begin
          strobes[p].we   = guardPass[p];
          strobes[p].data = wrVal[p];
        end
        OP_SETINV: begin
          strobes[p].we   = guardPass[p];
          strobes[p].data = ~wrVal[p];
        end
        OP_LOOP: begin
          strobes[p].we   = 1'b1;
          strobes[p].data = (cnt < bnd);
        end
        default: begin
          strobes[p].we   = 1'b0;
          strobes[p].data = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/predStore.sv
module predStore
  import predPkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_WR    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SLOTS*IDX_W-1:0] slotIdx,
  input  logic [NUM_WR*IDX_W-1:0]    guardIdx,
  input  wrStrobe_t                  strobes [NUM_WR],
  output logic [NUM_SLOTS-1:0]       slotPass,
  output logic [NUM_WR-1:0]          guardPass
);
  localparam logic [PRED_COUNT-1:0] RESET_BITS = {{(PRED_COUNT-1){1'b0}}, 1'b1};

  // Bit 0 is never written, so it keeps its reset value of 1.
  logic [PRED_COUNT-1:0] predBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predBits <= RESET_BITS;
    end else begin
      // Later ports overwrite earlier ones: highest port wins.
      for (int p = 0; p < NUM_WR; p++) begin
        if (strobes[p].we && (strobes[p].dest != '0)) begin
          predBits[strobes[p].dest] <= strobes[p].data;
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slotRd
    assign slotPass[s] = predBits[slotIdx[s*IDX_W +: IDX_W]];
  end

  for (genvar p = 0; p < NUM_WR; p++) begin : g_guardRd
    assign guardPass[p] = predBits[guardIdx[p*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/predRegFile.sv
module predRegFile
  import predPkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_WR    = 2,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SLOTS*IDX_W-1:0] slotIdx,
  output logic [NUM_SLOTS-1:0]       slotPass,
  input  logic [NUM_WR*2-1:0]        wrOp,
  input  logic [NUM_WR*IDX_W-1:0]    wrGuard,
  input  logic [NUM_WR*IDX_W-1:0]    wrDest,
  input  logic [NUM_WR-1:0]          wrVal,
  input  logic [NUM_WR*CNT_W-1:0]    loopCount,
  input  logic [NUM_WR*CNT_W-1:0]    loopBound
);
  wrStrobe_t         strobes [NUM_WR];
  logic [NUM_WR-1:0] guardPass;

  predCtrl #(.NUM_WR(NUM_WR), .CNT_W(CNT_W)) u_ctrl (
    .wrOp      (wrOp),
    .wrDest    (wrDest),
    .wrVal     (wrVal),
    .loopCount (loopCount),
    .loopBound (loopBound),
    .guardPass (guardPass),
    .strobes   (strobes)
  );

  predStore #(.NUM_SLOTS(NUM_SLOTS), .NUM_WR(NUM_WR)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .slotIdx   (slotIdx),
    .guardIdx  (wrGuard),
    .strobes   (strobes),
    .slotPass  (slotPass),
    .guardPass (guardPass)
  );
endmodule

// File: rtl/predRegFileChk.sv
module predRegFileChk
  import predPkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_WR    = 2,
  parameter int CNT_W     = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_SLOTS*IDX_W-1:0] slotIdx,
  input logic [NUM_SLOTS-1:0]       slotPass,
  input logic [NUM_WR*2-1:0]        wrOp,
  input logic [NUM_WR*IDX_W-1:0]    wrGuard,
  input logic [NUM_WR*IDX_W-1:0]    wrDest,
  input logic [NUM_WR-1:0]          wrVal,
  input logic [NUM_WR*CNT_W-1:0]    loopCount,
  input logic [NUM_WR*CNT_W-1:0]    loopBound,
  input logic [PRED_COUNT-1:0]      predBits
);
  localparam int HI = NUM_WR - 1;

  logic [1:0]       hiOp;
  logic [IDX_W-1:0] hiGuard;
  logic [IDX_W-1:0] hiDest;
  logic             hiVal;
  logic [CNT_W-1:0] hiCnt;
  logic [CNT_W-1:0] hiBnd;
  logic             hiGuardOk;
  logic             lowerQuiet;

  assign hiOp      = wrOp[HI*2 +: 2];
  assign hiGuard   = wrGuard[HI*IDX_W +: IDX_W];
  assign hiDest    = wrDest[HI*IDX_W +: IDX_W];
  assign hiVal     = wrVal[HI];
  assign hiCnt     = loopCount[HI*CNT_W +: CNT_W];
  assign hiBnd     = loopBound[HI*CNT_W +: CNT_W];
  assign hiGuardOk = predBits[hiGuard];

  always_comb begin
    lowerQuiet = 1'b1;
    for (int p = 0; p < HI; p++) begin
      if (wrOp[p*2 +: 2] != OP_NONE) lowerQuiet = 1'b0;
    end
  end

  // R2: slot naming register 0 always passes
  assert_zero_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx[IDX_W-1:0] == '0) |-> slotPass[0]);

  // R2: register 0 survives any write aimed at it
  assert_zero_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hiDest == '0) |=> predBits[0]);

  // R4: guarded set with a true guard stores the value
  assert_set_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hiOp == OP_SET && hiGuardOk && hiDest != '0)
      |=> predBits[$past(hiDest)] == $past(hiVal));

  // R5: inverted set with a true guard stores the complement
  assert_inv_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hiOp == OP_SETINV && hiGuardOk && hiDest != '0)
      |=> predBits[$past(hiDest)] == !$past(hiVal));

  // R6: a false guard drops the write
  assert_guard_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((hiOp == OP_SET || hiOp == OP_SETINV) && !hiGuardOk && lowerQuiet && hiDest != '0)
      |=> predBits[$past(hiDest)] == $past(predBits[hiDest]));

  // R7: loop compare is an unsigned below-bound test
  assert_loop_cmp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hiOp == OP_LOOP && hiDest != '0)
      |=> predBits[$past(hiDest)] == ($past(hiCnt) < $past(hiBnd)));
endmodule

bind predRegFile predRegFileChk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_WR(NUM_WR), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotIdx   (slotIdx),
  .slotPass  (slotPass),
  .wrOp      (wrOp),
  .wrGuard   (wrGuard),
  .wrDest    (wrDest),
  .wrVal     (wrVal),
  .loopCount (loopCount),
  .loopBound (loopBound),
  .predBits  (u_store.predBits)
);

// File: tb/predRegFile_bench.sv
module predRegFile_bench;
  localparam int NS = 7;
  localparam int NW = 2;
  localparam int CW = 32;
  localparam int IW = 7;
  localparam int NR = 128;

  logic             clk = 1'b0;
  logic             rstN;
  logic [NS*IW-1:0] slotIdx;
  logic [NS-1:0]    slotPass;
  logic [NW*2-1:0]  wrOp;
  logic [NW*IW-1:0] wrGuard;
  logic [NW*IW-1:0] wrDest;
  logic [NW-1:0]    wrVal;
  logic [NW*CW-1:0] loopCount;
  logic [NW*CW-1:0] loopBound;

  always #5 clk = ~clk;

  predRegFile #(.NUM_SLOTS(NS), .NUM_WR(NW), .CNT_W(CW)) u_predRegFile (
    .clk(clk), .rstN(rstN), .slotIdx(slotIdx), .slotPass(slotPass),
    .wrOp(wrOp), .wrGuard(wrGuard), .wrDest(wrDest), .wrVal(wrVal),
    .loopCount(loopCount), .loopBound(loopBound)
  );

  typedef struct {
    int    slot;
    logic  exp;
    int    idx;
    string tag;
  } item_t;

  item_t q[$];
  int    nTests = 0;
  int    nFails = 0;
  bit    done   = 1'b0;
  logic  mdl [NR];

  // Monitor: compares outputs well after the driver set the inputs.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        nTests++;
        if (slotPass[it.slot] !== it.exp) begin
          nFails++;
          $display("FAIL %s slot %0d reg %0d: got %b expected %b",
                   it.tag, it.slot, it.idx, slotPass[it.slot], it.exp);
        end
      end
    end
  end

  task automatic clearOps();
    wrOp = '0; wrGuard = '0; wrDest = '0; wrVal = '0;
    loopCount = '0; loopBound = '0;
  endtask

  task automatic setPort(int p, logic [1:0] op, int g, int d, logic v,
                         logic [CW-1:0] c, logic [CW-1:0] b);
    wrOp[p*2 +: 2]       = op;
    wrGuard[p*IW +: IW]  = IW'(g);
    wrDest[p*IW +: IW]   = IW'(d);
    wrVal[p]             = v;
    loopCount[p*CW +: CW] = c;
    loopBound[p*CW +: CW] = b;
  endtask

  task automatic setSlot(int s, int idx);
    slotIdx[s*IW +: IW] = IW'(idx);
  endtask

  // Driver: push expected pass flags from the old model, then apply writes.
  task automatic step(string tag);
    logic nxt [NR];
    for (int s = 0; s < NS; s++) begin
      item_t it;
      int    ix;
      ix = int'(slotIdx[s*IW +: IW]);
      it.slot = s; it.idx = ix; it.exp = mdl[ix]; it.tag = tag;
      q.push_back(it);
    end
    nxt = mdl;
    for (int p = 0; p < NW; p++) begin
      logic [1:0] op;
      int         d;
      logic       g;
      op = wrOp[p*2 +: 2];
      d  = int'(wrDest[p*IW +: IW]);
      g  = mdl[int'(wrGuard[p*IW +: IW])];
      if (d != 0) begin
        if (op == 2'b01 && g) nxt[d] = wrVal[p];
        if (op == 2'b10 && g) nxt[d] = ~wrVal[p];
        if (op == 2'b11) nxt[d] = (loopCount[p*CW +: CW] < loopBound[p*CW +: CW]);
      end
    end
    mdl = nxt;
    @(negedge clk);
    clearOps();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = (i == 0);
    rstN = 1'b0; slotIdx = '0; clearOps();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 R3: reset state seen on all slots
    setSlot(0, 0); setSlot(1, 1); setSlot(2, 5); setSlot(3, 64);
    setSlot(4, 127); setSlot(5, 2); setSlot(6, 3);
    step("R1 R3 reset");

    // R4 R8: guarded set, same-cycle read returns old 0
    setPort(0, 2'b01, 0, 5, 1'b1, 0, 0);
    setSlot(2, 5);
    step("R4 R8 same-cycle old");

    // R5: inverted set on both ports, guard is reg 5 (now 1) and reg 0
    setSlot(2, 5);
    setPort(0, 2'b10, 5, 6, 1'b1, 0, 0);
    setPort(1, 2'b10, 0, 7, 1'b0, 0, 0);
    step("R4 set visible");

    // R6: guards read 0, writes dropped
    setSlot(2, 6); setSlot(3, 7);
    setPort(0, 2'b01, 10, 8, 1'b1, 0, 0);
    setPort(1, 2'b10, 11, 9, 1'b0, 0, 0);
    step("R5 inverted");

    // R7: counter below bound / equal to bound
    setSlot(2, 8); setSlot(3, 9);
    setPort(0, 2'b11, 12, 20, 1'b0, 32'd3, 32'd4);
    setPort(1, 2'b11, 12, 21, 1'b1, 32'd4, 32'd4);
    step("R6 guard false dropped");

    // R7: unsigned extremes
    setSlot(2, 20); setSlot(3, 21);
    setPort(0, 2'b11, 0, 22, 1'b0, 32'hFFFF_FFFF, 32'd1);
    setPort(1, 2'b11, 0, 23, 1'b0, 32'd1, 32'hFFFF_FFFF);
    step("R7 below and equal");

    // R2: writes to register 0 ignored
    setSlot(2, 22); setSlot(3, 23);
    setPort(0, 2'b01, 0, 0, 1'b0, 0, 0);
    setPort(1, 2'b11, 0, 0, 1'b0, 32'd5, 32'd1);
    step("R7 unsigned extremes");

    // R9: both ports hit reg 30, port 1 writes 0
    for (int s = 0; s < NS; s++) setSlot(s, 0);
    setPort(0, 2'b01, 0, 30, 1'b1, 0, 0);
    setPort(1, 2'b01, 0, 30, 1'b0, 0, 0);
    step("R2 reg0 stays 1");

    // R9: reverse order, port 1 writes 1
    setSlot(1, 30);
    setPort(0, 2'b01, 0, 30, 1'b0, 0, 0);
    setPort(1, 2'b01, 0, 30, 1'b1, 0, 0);
    step("R9 port1 wins 0");

    // R10: op 00 aimed at reg 30 does nothing
    setSlot(1, 30);
    setPort(0, 2'b00, 0, 30, 1'b0, 0, 0);
    setPort(1, 2'b00, 0, 30, 1'b0, 0, 0);
    step("R9 port1 wins 1");

    setSlot(1, 30);
    step("R10 no-op write");

    // R3 R8: random traffic over a small index range
    for (int n = 0; n < 300; n++) begin
      for (int s = 0; s < NS; s++) setSlot(s, int'($urandom_range(0, 15)));
      for (int p = 0; p < NW; p++)
        setPort(p, 2'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                32'($urandom_range(0, 7)), 32'($urandom_range(0, 7)));
      step("R3 R8 random");
    end

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule